// File: doc/BRIEF.md
# Multiprocessor-Mode UART Receiver

This block receives asynchronous serial frames from a single line that is oversampled at 16 times the bit rate. The oversampling rate comes from an external `baud_tick` strobe. It turns each frame into a parallel byte and keeps sticky status for it: data-ready, framing error and overrun. From that status it raises two interrupt requests, one for received data and one for receive errors.

In multiprocessor format, every frame carries one extra bit after the data bits. A 1 in that bit marks the frame as an address, and a 0 marks it as data. Software can arm a wake-up filter. While the filter is armed, data frames are dropped completely: the frame is not transferred, no error is detected, no flag is set and no interrupt is raised. The first address frame clears the filter by itself, sets the multiprocessor-bit status, and is received normally. A node on a shared line can therefore sleep through traffic meant for other nodes.

Top module: `mpuart_rx`

## Requirements
- R1: After synchronous reset, `rx_ready`, `frm_err`, `ovr_err`, `rx_mpb`, `wake_armed`, `irq_rxd` and `irq_err` are 0, and `rx_data` is 0.
- R2: A frame has these bits in order: a start bit (0), 8 data bits with the LSB first, then one multiprocessor bit only when `mp_fmt` is 1, then a stop bit. When the frame is accepted, `rx_data` takes the data bits and `rx_mpb` takes the multiprocessor bit. `rx_mpb` takes 0 when `mp_fmt` is 0. `rx_ready` is then set.
- R3: A falling edge on the line starts a frame only if the line is still low at the 8th oversample tick. A low pulse shorter than that is ignored, and the frame after it is received correctly.
- R4: While `rx_en` is 0, no frame is received. Dropping `rx_en` leaves `rx_ready`, `frm_err`, `ovr_err` and `rx_data` unchanged.
- R5: An accepted frame whose stop bit samples as 0 sets `frm_err`, and `frm_err` stays set until it is cleared.
- R6: An accepted frame that completes while `rx_ready` is still 1 sets `ovr_err` and leaves `rx_data` and `rx_mpb` at their old values.
- R7: While `wake_armed` and `mp_fmt` are both 1, a frame whose multiprocessor bit is 0 changes none of `rx_data`, `rx_mpb`, `rx_ready`, `frm_err` or `ovr_err`. This holds even when its stop bit is bad.
- R8: While the filter is active, a frame whose multiprocessor bit is 1 sets `rx_mpb` and clears `wake_armed`, and the frame is then accepted as normal.
- R9: When `mp_fmt` is 0, `wake_armed` has no effect: frames are accepted normally and `wake_armed` keeps its value.
- R10: `irq_rxd` equals `rx_ie` AND `rx_ready`. `irq_err` equals `rx_ie` AND (`frm_err` OR `ovr_err`). Both are forced to 0 while `wake_armed` AND `mp_fmt` is 1.
- R11: A pulse on `rdy_clr` clears `rx_ready`. A pulse on `err_clr` clears `frm_err` and `ovr_err`.
- R12: A pulse on `wake_wr` loads `wake_val` into `wake_armed`. If the write falls in the same cycle as the self-clear, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| mp_fmt | input | 1 | Selects the multiprocessor frame format |
| rx_ie | input | 1 | Receive interrupt enable |
| wake_wr | input | 1 | Write strobe for the wake-up filter |
| wake_val | input | 1 | Value loaded by `wake_wr` |
| rdy_clr | input | 1 | Clears data-ready |
| err_clr | input | 1 | Clears the framing and overrun flags |
| baud_tick | input | 1 | Oversample strobe at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| rx_data | output | 8 | Received byte |
| rx_mpb | output | 1 | Received multiprocessor bit |
| rx_ready | output | 1 | Data-ready flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun flag |
| wake_armed | output | 1 | Current state of the wake-up filter |
| irq_rxd | output | 1 | Receive-data interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
Directed frames come first, in both formats, with a good or a bad stop bit. They separate correct bit ordering and multiprocessor-bit placement from an off-by-one in the bit count. Further directed cases cover a short start glitch, reception with `rx_en` low, and a second frame held back by a full buffer. Each of these is detected only by its own mechanism: start validation, the enable gate and overrun.

With the filter armed, data frames with bad stop bits are sent before an address frame. This shows that the filter hides errors as well as data, and that it clears only on the address frame. Random frames then mix in random data, multiprocessor bits, stop bits, clears, interrupt enables and filter writes. Each is checked against a bench model of the flags, which exposes faults in sticky or priority behaviour.

// File: rtl/mpuart_rx_pkg.sv
package mpuart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP,
    RX_WAITHI
  } rx_state_e;
endpackage

// File: rtl/mpuart_rx_sync.sv
module mpuart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mpuart_rx_deser.sv
module mpuart_rx_deser
  import mpuart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              mp_fmt,
  input  logic              tick,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] f_data,
  output logic              f_mpb,
  output logic              f_stop_ok
);
  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LAST_MP   = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] LAST_NOMP = BIT_W'(DATA_W - 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W:0]   shreg;
  logic              fmt_q;
  logic [BIT_W-1:0]  last_idx;

  assign last_idx = fmt_q ? LAST_MP : LAST_NOMP;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      fmt_q     <= 1'b0;
      done      <= 1'b0;
      f_data    <= '0;
      f_mpb     <= 1'b0;
      f_stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!rx_en) begin
        st  <= RX_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          RX_IDLE: begin
            if (tick && !rxd) begin
              st    <= RX_START;
              cnt   <= '0;
              fmt_q <= mp_fmt;
            end
          end
          RX_START: begin
            if (tick) begin
              if (cnt == CNT_MID) begin
                cnt     <= '0;
                bit_idx <= '0;
                st      <= rxd ? RX_IDLE : RX_BITS;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          RX_BITS: begin
            if (tick) begin
              if (cnt == CNT_LAST) begin
                cnt     <= '0;
                shreg   <= {rxd, shreg[DATA_W:1]};
                bit_idx <= bit_idx + 1'b1;
                if (bit_idx == last_idx) st <= RX_STOP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          RX_STOP: begin
            if (tick) begin
              if (cnt == CNT_LAST) begin
                cnt       <= '0;
                done      <= 1'b1;
                f_stop_ok <= rxd;
                if (fmt_q) begin
                  f_data <= shreg[DATA_W-1:0];
                  f_mpb  <= shreg[DATA_W];
                end else begin
                  f_data <= shreg[DATA_W:1];
                  f_mpb  <= 1'b0;
                end
                st <= rxd ? RX_IDLE : RX_WAITHI;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          RX_WAITHI: begin
            if (rxd) st <= RX_IDLE;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R3: a start candidate that is high again at mid-bit is dropped
  assert_glitch_reject_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_en && st == RX_START && tick && cnt == CNT_MID && rxd) |=> st == RX_IDLE);

  // R4: with reception disabled the deserializer idles and completes nothing
  assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!rx_en) |=> (st == RX_IDLE && !done));
endmodule

// File: rtl/mpuart_rx_flags.sv
module mpuart_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mp_fmt,
  input  logic              rx_ie,
  input  logic              wake_wr,
  input  logic              wake_val,
  input  logic              rdy_clr,
  input  logic              err_clr,
  input  logic              done,
  input  logic [DATA_W-1:0] f_data,
  input  logic              f_mpb,
  input  logic              f_stop_ok,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_ready,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              wake_armed,
  output logic              irq_rxd,
  output logic              irq_err
);
  logic filt;
  logic wake_hit;
  logic accept;

  assign filt     = wake_armed & mp_fmt;
  assign wake_hit = done & filt & f_mpb;
  assign accept   = done & (~filt | f_mpb);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      rx_mpb     <= 1'b0;
      rx_ready   <= 1'b0;
      frm_err    <= 1'b0;
      ovr_err    <= 1'b0;
      wake_armed <= 1'b0;
      irq_rxd    <= 1'b0;
      irq_err    <= 1'b0;
    end else begin
      if (rdy_clr) rx_ready <= 1'b0;
      if (err_clr) begin
        frm_err <= 1'b0;
        ovr_err <= 1'b0;
      end
      if (wake_wr)       wake_armed <= wake_val;
      else if (wake_hit) wake_armed <= 1'b0;
      if (wake_hit) rx_mpb <= 1'b1;
      if (accept) begin
        if (rx_ready) begin
          ovr_err <= 1'b1;
        end else begin
          rx_ready <= 1'b1;
          rx_data  <= f_data;
          rx_mpb   <= f_mpb;
          if (!f_stop_ok) frm_err <= 1'b1;
        end
      end
      irq_rxd <= rx_ie & rx_ready & ~filt;
      irq_err <= rx_ie & (frm_err | ovr_err) & ~filt;
    end
  end

  // R7: a filtered data frame leaves every receive flag and the byte alone
  assert_filter_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (done && filt && !f_mpb) |=>
      ($stable(rx_data) && !$rose(rx_ready) && !$rose(frm_err) && !$rose(ovr_err)));

  // R8: an address frame while filtering clears the filter and flags the bit
  assert_wake_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wake_hit && !wake_wr) |=> (!wake_armed && rx_mpb));

  // R6: a frame landing on a full buffer raises overrun and keeps the byte
  assert_overrun_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && rx_ready) |=> (ovr_err && $stable(rx_data)));

  // R10: no interrupt without enable, none while the filter holds
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_rxd || irq_err) |-> $past(rx_ie && !(wake_armed && mp_fmt)));

  // R12: a software write always sets the filter state
  assert_wake_write_R12: assert property (@(posedge clk) disable iff (rst)
    wake_wr |=> (wake_armed == $past(wake_val)));
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              mp_fmt,
  input  logic              rx_ie,
  input  logic              wake_wr,
  input  logic              wake_val,
  input  logic              rdy_clr,
  input  logic              err_clr,
  input  logic              baud_tick,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_ready,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              wake_armed,
  output logic              irq_rxd,
  output logic              irq_err
);
  logic              rxd_s;
  logic              done;
  logic [DATA_W-1:0] f_data;
  logic              f_mpb;
  logic              f_stop_ok;

  mpuart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rxd_s)
  );

  mpuart_rx_deser #(.DATA_W(DATA_W), .OSR(OSR)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .mp_fmt   (mp_fmt),
    .tick     (baud_tick),
    .rxd      (rxd_s),
    .done     (done),
    .f_data   (f_data),
    .f_mpb    (f_mpb),
    .f_stop_ok(f_stop_ok)
  );

  mpuart_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .mp_fmt    (mp_fmt),
    .rx_ie     (rx_ie),
    .wake_wr   (wake_wr),
    .wake_val  (wake_val),
    .rdy_clr   (rdy_clr),
    .err_clr   (err_clr),
    .done      (done),
    .f_data    (f_data),
    .f_mpb     (f_mpb),
    .f_stop_ok (f_stop_ok),
    .rx_data   (rx_data),
    .rx_mpb    (rx_mpb),
    .rx_ready  (rx_ready),
    .frm_err   (frm_err),
    .ovr_err   (ovr_err),
    .wake_armed(wake_armed),
    .irq_rxd   (irq_rxd),
    .irq_err   (irq_err)
  );
endmodule

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int OSR        = 16;
  localparam int BIT_CYC    = OSR * TICK_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, mp_fmt = 1'b0, rx_ie = 1'b0;
  logic wake_wr = 1'b0, wake_val = 1'b0, rdy_clr = 1'b0, err_clr = 1'b0;
  logic baud_tick = 1'b0;
  logic rxd = 1'b1;
  logic [7:0] rx_data;
  logic rx_mpb, rx_ready, frm_err, ovr_err, wake_armed, irq_rxd, irq_err;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_data;
  logic m_mpb, m_rdy, m_frm, m_ovr, m_wake;

  always #(CLK_PERIOD/2) clk = ~clk;

  int tick_cnt = 0;
  always @(posedge clk) begin
    tick_cnt  <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    baud_tick <= (tick_cnt == TICK_DIV - 1);
  end

  mpuart_rx u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .mp_fmt(mp_fmt), .rx_ie(rx_ie),
    .wake_wr(wake_wr), .wake_val(wake_val), .rdy_clr(rdy_clr), .err_clr(err_clr),
    .baud_tick(baud_tick), .rxd(rxd),
    .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_ready(rx_ready), .frm_err(frm_err),
    .ovr_err(ovr_err), .wake_armed(wake_armed), .irq_rxd(irq_rxd), .irq_err(irq_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_irq_rxd();
    return rx_ie & m_rdy & ~(m_wake & mp_fmt);
  endfunction

  function automatic logic exp_irq_err();
    return rx_ie & (m_frm | m_ovr) & ~(m_wake & mp_fmt);
  endfunction

  task automatic check_all(input string req);
    chk(req, "rx_data", int'(rx_data), int'(m_data));
    chk(req, "rx_mpb", int'(rx_mpb), int'(m_mpb));
    chk(req, "rx_ready", int'(rx_ready), int'(m_rdy));
    chk(req, "frm_err", int'(frm_err), int'(m_frm));
    chk(req, "ovr_err", int'(ovr_err), int'(m_ovr));
    chk(req, "wake_armed", int'(wake_armed), int'(m_wake));
    chk(req, "irq_rxd", int'(irq_rxd), int'(exp_irq_rxd()));
    chk(req, "irq_err", int'(irq_err), int'(exp_irq_err()));
  endtask

  // bench model of one completed frame
  task automatic model_frame(input logic [7:0] d, input logic mb, input logic stop_ok);
    logic mb_eff;
    mb_eff = mp_fmt ? mb : 1'b0;
    if (m_wake && mp_fmt && !mb_eff) return;
    if (m_wake && mp_fmt && mb_eff) begin
      m_wake = 1'b0;
      m_mpb  = 1'b1;
    end
    if (m_rdy) begin
      m_ovr = 1'b1;
    end else begin
      m_rdy  = 1'b1;
      m_data = d;
      m_mpb  = mb_eff;
      if (!stop_ok) m_frm = 1'b1;
    end
  endtask

  task automatic hold_bit(input logic b);
    rxd = b;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic mb, input logic stop_ok);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (mp_fmt) hold_bit(mb);
    hold_bit(stop_ok);
    hold_bit(1'b1);
    hold_bit(1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_rdy_clr();
    rdy_clr = 1'b1; @(negedge clk); rdy_clr = 1'b0;
    m_rdy = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_err_clr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    m_frm = 1'b0; m_ovr = 1'b0; @(negedge clk);
  endtask

  task automatic write_wake(input logic v);
    wake_val = v; wake_wr = 1'b1; @(negedge clk); wake_wr = 1'b0;
    m_wake = v; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_data = '0; m_mpb = 0; m_rdy = 0; m_frm = 0; m_ovr = 0; m_wake = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");

    rx_en = 1'b1; rx_ie = 1'b1;
    // R2 plain format, LSB-first ordering
    send_frame(8'hA5, 1'b1, 1'b1); model_frame(8'hA5, 1'b1, 1'b1);
    check_all("R2");
    check_all("R10");
    pulse_rdy_clr(); check_all("R11");

    // R2 multiprocessor format
    mp_fmt = 1'b1;
    send_frame(8'h3C, 1'b1, 1'b1); model_frame(8'h3C, 1'b1, 1'b1);
    check_all("R2");
    pulse_rdy_clr();

    // R5 framing error
    send_frame(8'h81, 1'b0, 1'b0); model_frame(8'h81, 1'b0, 1'b0);
    check_all("R5");
    check_all("R10");
    pulse_err_clr(); check_all("R11");

    // R6 overrun: buffer still full
    send_frame(8'h5A, 1'b1, 1'b1); model_frame(8'h5A, 1'b1, 1'b1);
    check_all("R6");
    pulse_rdy_clr(); pulse_err_clr();

    // R4 disabled receiver keeps flags and takes no frame
    send_frame(8'h11, 1'b0, 1'b1); model_frame(8'h11, 1'b0, 1'b1);
    rx_en = 1'b0; repeat (4) @(negedge clk);
    check_all("R4");
    send_frame(8'hEE, 1'b1, 1'b0);
    check_all("R4");
    rx_en = 1'b1; pulse_rdy_clr();

    // R3 short low glitch, then a good frame
    rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (4 * BIT_CYC) @(negedge clk);
    check_all("R3");
    send_frame(8'hC3, 1'b0, 1'b1); model_frame(8'hC3, 1'b0, 1'b1);
    check_all("R3");
    pulse_rdy_clr();

    // R12 software write of the filter
    write_wake(1'b1); check_all("R12");
    check_all("R10");
    // R7 data frames filtered, even with bad stop
    send_frame(8'h77, 1'b0, 1'b0); model_frame(8'h77, 1'b0, 1'b0);
    check_all("R7");
    send_frame(8'h99, 1'b0, 1'b1); model_frame(8'h99, 1'b0, 1'b1);
    check_all("R7");
    // R8 address frame wakes the receiver
    send_frame(8'h42, 1'b1, 1'b1); model_frame(8'h42, 1'b1, 1'b1);
    check_all("R8");
    pulse_rdy_clr();
    write_wake(1'b1); write_wake(1'b0); check_all("R12");

    // R9 filter has no effect in plain format
    mp_fmt = 1'b0; write_wake(1'b1);
    send_frame(8'h1E, 1'b0, 1'b1); model_frame(8'h1E, 1'b0, 1'b1);
    check_all("R9");
    pulse_rdy_clr(); write_wake(1'b0);

    // random mix in both formats
    for (int k = 0; k < 24; k++) begin
      logic [7:0] d;
      logic mb, sok;
      d   = 8'($urandom);
      mb  = 1'($urandom);
      sok = ($urandom % 6) != 0;
      mp_fmt = (k >= 8);
      rx_ie  = 1'($urandom);
      if (($urandom % 3) == 0) write_wake(1'($urandom));
      if (($urandom % 2) == 0) pulse_rdy_clr();
      if (($urandom % 3) == 0) pulse_err_clr();
      send_frame(d, mb, sok); model_frame(d, mb, sok);
      check_all("R2");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule